// File: doc/BRIEF.md
# Calendar Clock with Update Cycle

This block keeps wall-clock time and the calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A reference tick enable drives a phase counter. One full second equals a fixed number of ticks. At the end of each second all fields advance together, and carries ripple from seconds up to the year. A status bit warns software ahead of each advance and stays high until the advance is done. This tells software when a multi-byte read of the time could tear.

Software reaches the block through a byte-wide register port with a 4-bit index. The write path loads time fields and the mode register. The read path returns every field formatted in the current mode. A mode bit chooses BCD or plain binary values. Another chooses 24-hour or 12-hour hours, with a PM flag in the top bit. A freeze bit stops all advancing while a new time is loaded. When it is released, a fresh, full second starts. Two outputs serve neighbouring logic: an update-ended pulse, and an alarm-check strobe that a comparator elsewhere uses.

Top module: `cal_clock`

## Requirements
- R1: The seconds (index 0), minutes (index 2) and hours (index 4) fields advance once per second. Seconds wrap 59 to 0 and carry into minutes, minutes wrap 59 to 0 and carry into hours, and hours wrap 23 to 0.
- R2: At the midnight carry, four fields change:
  - day of week (index 6) counts 1 to 7 and then returns to 1.
  - day of month (index 7) returns to 1 after the month's last day: 30 for months 4, 6, 9 and 11, 31 for the other months, and for February 29 when the year is divisible by 4 and 28 otherwise.
  - month (index 8) wraps 12 to 1.
  - year (index 9) wraps 99 to 0.
- R3: Bit 7 of index 10 is the update-in-progress flag. With the phase counter counting ticks 0 to TICKS_PER_SEC-1, the flag is high while the counter is at or above TICKS_PER_SEC-UIP_LEAD_TICKS-UPD_TICKS, so it covers the warning interval and the update interval. It drops in the cycle the new time appears. The other bits of index 10 read 0.
- R4: `upd_done_o` and `alarm_chk_o` are high for exactly one cycle. That cycle is the one in which the advanced time is first readable.
- R5: When bit 2 of index 11 is set, fields are read and written as plain binary. When it is clear, they are read and written as packed BCD (tens in bits 7:4, units in bits 3:0).
- R6: While bit 7 of index 11 is set, the following hold:
  - no field advances.
  - no update pulse occurs.
  - the update flag is low.
  - the phase counter is held at 0, so the first advance after release comes TICKS_PER_SEC ticks later.
- R7: When bit 1 of index 11 is clear (12-hour mode), the hours byte holds the hour 12, 1 to 11 in bits 6:0 and a PM flag in bit 7. The flag sets on the change from 11 to 12 in the morning and clears from 11 PM to 12 AM. Hour writes in this mode use the same encoding.
- R8: A write to index 0, 2, 4, 6, 7, 8 or 9 loads that field in the cycle after the write. A write to index 11 keeps bits 7, 2 and 1 and reads back with all other bits 0. Writes to any other index change nothing, and those indices read 0 except 10 and 13.
- R9: Index 13 always reads 0x80, the valid-time indicator.
- R10: After reset the block holds the following:
  - time 00:00:00, day of week 1, date 1, month 1, year 0.
  - mode: 24-hour, BCD, not frozen (index 11 reads 0x02).
  - phase counter at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Reference tick enable, one per phase step |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write index |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 4 | Register read index |
| rd_data_o | output | 8 | Register read data (combinational) |
| uip_o | output | 1 | Update-in-progress flag |
| upd_done_o | output | 1 | One-cycle update-ended pulse |
| alarm_chk_o | output | 1 | One-cycle alarm-check strobe |

## Verification
The bench builds the block with TICKS_PER_SEC = 16, a 3-tick warning lead and a 2-tick update interval. With these values one second is 16 cycles, and the whole flag window and its edges can be seen in a handful of cycles. Freezing the clock and loading times just before midnight brings the following within a few seconds of simulation:
- month-end, leap-February and century rollovers.
- the 12-hour PM transitions.
- a run with a sparse tick, which shows that the phase counts ticks rather than cycles.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam logic [3:0] IDX_SEC  = 4'd0;
    localparam logic [3:0] IDX_MIN  = 4'd2;
    localparam logic [3:0] IDX_HOUR = 4'd4;
    localparam logic [3:0] IDX_DOW  = 4'd6;
    localparam logic [3:0] IDX_DOM  = 4'd7;
    localparam logic [3:0] IDX_MON  = 4'd8;
    localparam logic [3:0] IDX_YEAR = 4'd9;
    localparam logic [3:0] IDX_STA  = 4'd10;
    localparam logic [3:0] IDX_MODE = 4'd11;
    localparam logic [3:0] IDX_VLD  = 4'd13;

    // Time held as binary counters; formatting happens at the register port.
    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] dom;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic freeze;
        logic binary;
        logic h24;
    } cal_mode_t;

    typedef enum logic [2:0] {
        F_NONE, F_SEC, F_MIN, F_HOUR, F_DOW, F_DOM, F_MON, F_YEAR
    } cal_field_e;

    typedef struct packed {
        cal_field_e fld;
        logic [6:0] val;
    } cal_wr_t;

    function automatic logic [7:0] to_bcd(logic [6:0] v);
        logic [3:0] tens;
        logic [3:0] units;
        tens  = 4'(v / 7'd10);
        units = 4'(v - 7'(tens) * 7'd10);
        return {tens, units};
    endfunction

    function automatic logic [6:0] from_bcd(logic [7:0] d);
        return 7'({4'd0, d[7:4]} * 8'd10 + {4'd0, d[3:0]});
    endfunction

    function automatic logic [7:0] enc(logic [6:0] v, logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic logic [6:0] dec(logic [7:0] d, logic bin);
        return bin ? d[6:0] : from_bcd(d);
    endfunction

    function automatic logic [4:0] days_in_month(logic [3:0] mon, logic [6:0] yr);
        case (mon)
            4'd2:                      return (yr[1:0] == 2'd0) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

    function automatic logic [7:0] hour_out(logic [4:0] h, logic h24, logic bin);
        logic [6:0] h12;
        logic       pm;
        if (h24) return enc({2'b00, h}, bin);
        pm = (h >= 5'd12);
        if (h == 5'd0)       h12 = 7'd12;
        else if (h > 5'd12)  h12 = {2'b00, h - 5'd12};
        else                 h12 = {2'b00, h};
        return enc(h12, bin) | {pm, 7'd0};
    endfunction

    function automatic logic [6:0] hour_in(logic [7:0] d, logic h24, logic bin);
        logic [6:0] v;
        if (h24) return dec(d, bin);
        v = dec({1'b0, d[6:0]}, bin);
        if (v == 7'd12) return d[7] ? 7'd12 : 7'd0;
        return d[7] ? v + 7'd12 : v;
    endfunction

endpackage

// File: rtl/cal_phase_seq.sv
module cal_phase_seq #(
    parameter int unsigned TICKS_PER_SEC  = 32768,
    parameter int unsigned UIP_LEAD_TICKS = 8,
    parameter int unsigned UPD_TICKS      = 65
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic freeze_i,
    output logic uip_o,
    output logic adv_o
);
    localparam int unsigned PW     = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int unsigned WIN    = UIP_LEAD_TICKS + UPD_TICKS;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

    logic [PW-1:0] ph_q;

    assign adv_o = tick_i & ~freeze_i & (ph_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || freeze_i)  ph_q <= '0;
        else if (adv_o)         ph_q <= '0;
        else if (tick_i)        ph_q <= ph_q + 1'b1;
    end

    generate
        if (WIN == 0) begin : g_no_window
            assign uip_o = 1'b0;
        end else begin : g_window
            localparam logic [PW-1:0] WSTART = PW'(TICKS_PER_SEC - WIN);
            assign uip_o = (ph_q >= WSTART);
        end
    endgenerate
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
    import cal_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      adv_i,
    input  cal_wr_t   wr_i,
    output cal_time_t time_o,
    output logic      done_o
);
    cal_time_t t_q;
    cal_time_t nxt;
    logic      c_min, c_hour, c_day, c_mon, c_year;
    logic [4:0] dim;

    always_comb begin
        dim    = days_in_month(t_q.mon, t_q.year);
        nxt    = t_q;
        c_min  = (t_q.sec >= 6'd59);
        c_hour = c_min  && (t_q.min  >= 6'd59);
        c_day  = c_hour && (t_q.hour >= 5'd23);
        c_mon  = c_day  && (t_q.dom  >= dim);
        c_year = c_mon  && (t_q.mon  >= 4'd12);

        nxt.sec = c_min ? 6'd0 : t_q.sec + 6'd1;
        if (c_min)  nxt.min  = c_hour ? 6'd0 : t_q.min + 6'd1;
        if (c_hour) nxt.hour = c_day  ? 5'd0 : t_q.hour + 5'd1;
        if (c_day) begin
            nxt.dow = (t_q.dow >= 3'd7) ? 3'd1 : t_q.dow + 3'd1;
            nxt.dom = c_mon ? 5'd1 : t_q.dom + 5'd1;
        end
        if (c_mon)  nxt.mon  = c_year ? 4'd1 : t_q.mon + 4'd1;
        if (c_year) nxt.year = (t_q.year >= 7'd99) ? 7'd0 : t_q.year + 7'd1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            t_q    <= '{year: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd1,
                        hour: 5'd0, min: 6'd0, sec: 6'd0};
            done_o <= 1'b0;
        end else begin
            done_o <= adv_i;
            if (adv_i) t_q <= nxt;
            case (wr_i.fld)
                F_SEC:   t_q.sec  <= wr_i.val[5:0];
                F_MIN:   t_q.min  <= wr_i.val[5:0];
                F_HOUR:  t_q.hour <= wr_i.val[4:0];
                F_DOW:   t_q.dow  <= wr_i.val[2:0];
                F_DOM:   t_q.dom  <= wr_i.val[4:0];
                F_MON:   t_q.mon  <= wr_i.val[3:0];
                F_YEAR:  t_q.year <= wr_i.val;
                default: ;
            endcase
        end
    end

    assign time_o = t_q;
endmodule

// File: rtl/cal_reg_port.sv
module cal_reg_port
    import cal_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      wr_en_i,
    input  logic [3:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [3:0] rd_addr_i,
    input  cal_time_t time_i,
    input  logic      uip_i,
    output cal_wr_t   wr_o,
    output cal_mode_t mode_o,
    output logic [7:0] rd_data_o
);
    cal_mode_t mode_q;
    logic      bin;

    assign bin    = mode_q.binary;
    assign mode_o = mode_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            mode_q <= '{freeze: 1'b0, binary: 1'b0, h24: 1'b1};
        else if (wr_en_i && wr_addr_i == IDX_MODE)
            mode_q <= '{freeze: wr_data_i[7], binary: wr_data_i[2], h24: wr_data_i[1]};
    end

    always_comb begin
        wr_o = '{fld: F_NONE, val: 7'd0};
        if (wr_en_i) begin
            case (wr_addr_i)
                IDX_SEC:  wr_o = '{fld: F_SEC,  val: dec(wr_data_i, bin)};
                IDX_MIN:  wr_o = '{fld: F_MIN,  val: dec(wr_data_i, bin)};
                IDX_HOUR: wr_o = '{fld: F_HOUR, val: hour_in(wr_data_i, mode_q.h24, bin)};
                IDX_DOW:  wr_o = '{fld: F_DOW,  val: dec(wr_data_i, bin)};
                IDX_DOM:  wr_o = '{fld: F_DOM,  val: dec(wr_data_i, bin)};
                IDX_MON:  wr_o = '{fld: F_MON,  val: dec(wr_data_i, bin)};
                IDX_YEAR: wr_o = '{fld: F_YEAR, val: dec(wr_data_i, bin)};
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr_i)
            IDX_SEC:  rd_data_o = enc({1'b0, time_i.sec}, bin);
            IDX_MIN:  rd_data_o = enc({1'b0, time_i.min}, bin);
            IDX_HOUR: rd_data_o = hour_out(time_i.hour, mode_q.h24, bin);
            IDX_DOW:  rd_data_o = enc({4'd0, time_i.dow}, bin);
            IDX_DOM:  rd_data_o = enc({2'd0, time_i.dom}, bin);
            IDX_MON:  rd_data_o = enc({3'd0, time_i.mon}, bin);
            IDX_YEAR: rd_data_o = enc(time_i.year, bin);
            IDX_STA:  rd_data_o = {uip_i, 7'd0};
            IDX_MODE: rd_data_o = {mode_q.freeze, 4'd0, mode_q.binary, mode_q.h24, 1'b0};
            IDX_VLD:  rd_data_o = 8'h80;
            default:  rd_data_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC  = 32768,
    parameter int unsigned UIP_LEAD_TICKS = 8,
    parameter int unsigned UPD_TICKS      = 65
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [3:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       uip_o,
    output logic       upd_done_o,
    output logic       alarm_chk_o
);
    cal_time_t time_q;
    cal_mode_t mode;
    cal_wr_t   wr_cmd;
    logic      adv;
    logic      done;

    cal_phase_seq #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_LEAD_TICKS(UIP_LEAD_TICKS),
        .UPD_TICKS     (UPD_TICKS)
    ) u_seq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick_i),
        .freeze_i(mode.freeze),
        .uip_o   (uip_o),
        .adv_o   (adv)
    );

    cal_time_core u_core (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .adv_i (adv),
        .wr_i  (wr_cmd),
        .time_o(time_q),
        .done_o(done)
    );

    cal_reg_port u_port (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i),
        .time_i   (time_q),
        .uip_i    (uip_o),
        .wr_o     (wr_cmd),
        .mode_o   (mode),
        .rd_data_o(rd_data_o)
    );

    assign upd_done_o  = done;
    assign alarm_chk_o = done;
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       wr_en_i,
    input logic       freeze_i,
    input logic [5:0] sec_i,
    input logic       uip_i,
    input logic       upd_done_i,
    input logic       alarm_chk_i
);
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_done_i |=> !upd_done_i);                                      // R4
    AST_ALARM_WITH_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        alarm_chk_i |-> upd_done_i);                                      // R4
    AST_UIP_CLEARS_ON_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_done_i |-> !uip_i);                                           // R3
    AST_UIP_PRECEDES_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_done_i |-> $past(uip_i));                                     // R3
    AST_FROZEN_NO_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(freeze_i) |-> !upd_done_i);                                 // R6
    AST_FROZEN_NO_UIP: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(freeze_i) && freeze_i) |-> !uip_i);                        // R6
    AST_SEC_ONLY_ON_EVENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (!upd_done_i && !$past(wr_en_i)) |-> $stable(sec_i));             // R1
endmodule

bind cal_clock cal_clock_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .freeze_i   (mode.freeze),
    .sec_i      (time_q.sec),
    .uip_i      (uip_o),
    .upd_done_i (upd_done_o),
    .alarm_chk_i(alarm_chk_o)
);

// File: tb/cal_clock_tb_top.sv
`timescale 1ns/1ps
module cal_clock_tb_top;
    localparam int TPS  = 16;
    localparam int LEAD = 3;
    localparam int UPD  = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [3:0] rd_addr = 4'd0;
    logic [7:0] rd_data;
    logic       uip, upd_done, alarm_chk;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_on  = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int mp, ms, mm, mh, mdw, mdd, mmo, my;
    int mfrz, mbin, mh24, mdone, pristine;

    always #4 clk = ~clk;

    cal_clock #(.TICKS_PER_SEC(TPS), .UIP_LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) dut_i (
        .clk_i(clk), .rst_i(rst), .tick_i(tick),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .uip_o(uip), .upd_done_o(upd_done), .alarm_chk_o(alarm_chk)
    );

    function automatic int m_dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int fmt(int v);
        return mbin ? v : ((v / 10) * 16 + v % 10);
    endfunction

    function automatic int unfmt(int d);
        return mbin ? d : ((d / 16) * 10 + d % 16);
    endfunction

    task automatic m_advance();
        int lim;
        lim = m_dim(mmo, my);
        ms++;
        if (ms >= 60) begin
            ms = 0; mm++;
            if (mm >= 60) begin
                mm = 0; mh++;
                if (mh >= 24) begin
                    mh = 0;
                    mdw = (mdw == 7) ? 1 : mdw + 1;
                    mdd++;
                    if (mdd > lim) begin
                        mdd = 1; mmo++;
                        if (mmo > 12) begin mmo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic m_write(int a, int d);
        int h12;
        case (a)
            0: ms = unfmt(d);
            2: mm = unfmt(d);
            4: begin
                if (mh24) mh = unfmt(d);
                else begin
                    h12 = unfmt(d % 128);
                    if (d >= 128) mh = (h12 == 12) ? 12 : h12 + 12;
                    else          mh = (h12 == 12) ? 0 : h12;
                end
            end
            6: mdw = unfmt(d);
            7: mdd = unfmt(d);
            8: mmo = unfmt(d);
            9: my  = unfmt(d);
            11: begin mfrz = (d >> 7) & 1; mbin = (d >> 2) & 1; mh24 = (d >> 1) & 1; end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        int adv;
        if (rst) begin
            mp = 0; ms = 0; mm = 0; mh = 0; mdw = 1; mdd = 1; mmo = 1; my = 0;
            mfrz = 0; mbin = 0; mh24 = 1; mdone = 0; pristine = 1;
        end else begin
            adv = (tick && !mfrz && mp == TPS - 1) ? 1 : 0;
            mdone = adv;
            if (mfrz) mp = 0;
            else if (tick) mp = adv ? 0 : mp + 1;
            if (adv) begin m_advance(); pristine = 0; end
            if (wr_en) begin m_write(int'(wr_addr), int'(wr_data)); pristine = 0; end
        end
    end

    function automatic int exp_rd(int a);
        int h12, pm;
        case (a)
            0: return fmt(ms);
            2: return fmt(mm);
            4: begin
                if (mh24) return fmt(mh);
                pm  = (mh >= 12) ? 128 : 0;
                h12 = (mh == 0) ? 12 : ((mh > 12) ? mh - 12 : mh);
                return pm + fmt(h12);
            end
            6: return fmt(mdw);
            7: return fmt(mdd);
            8: return fmt(mmo);
            9: return fmt(my);
            10: return (mp >= TPS - LEAD - UPD) ? 128 : 0;
            11: return mfrz * 128 + mbin * 4 + mh24 * 2;
            13: return 128;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        if (pristine) return "R10";
        case (a)
            0, 2: return mfrz ? "R6" : (mbin ? "R5" : "R1");
            4: return !mh24 ? "R7" : (mbin ? "R5" : "R1");
            6, 7, 8, 9: return mfrz ? "R6" : "R2";
            10: return "R3";
            11: return "R6";
            13: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic check(int act, int exp, string tag, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int exp_uip;
        if (chk_on && !finished) begin
            exp_uip = (mp >= TPS - LEAD - UPD) ? 1 : 0;
            check(int'(uip), exp_uip, "R3", "uip_o");
            check(int'(upd_done), mdone, "R4", "upd_done_o");
            check(int'(alarm_chk), mdone, "R4", "alarm_chk_o");
            check(int'(rd_data), exp_rd(int'(rd_addr)), tag_of(int'(rd_addr)),
                  $sformatf("rd_data_o idx %0d", rd_addr));
            rd_addr = (rd_addr == 4'd13) ? 4'd0 : rd_addr + 4'd1;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // freeze, load a full date/time, release (24h/BCD unless mode given)
    task automatic load(input logic [7:0] mode, input logic [7:0] yr, input logic [7:0] mo,
                        input logic [7:0] dd, input logic [7:0] dw, input logic [7:0] hh,
                        input logic [7:0] mi, input logic [7:0] ss);
        wr(4'd11, mode | 8'h80);
        wr(4'd9, yr); wr(4'd8, mo); wr(4'd7, dd); wr(4'd6, dw);
        wr(4'd4, hh); wr(4'd2, mi); wr(4'd0, ss);
        wr(4'd11, mode);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2; rst = 1'b0; chk_on = 1'b1;
        idle(40);                                                          // R10 R1 R3 R4
        load(8'h02, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58); idle(40); // R2 non-leap Feb
        load(8'h02, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); idle(24); // R2 leap day
        load(8'h02, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59); idle(24);
        load(8'h02, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59); idle(24); // R2 year wrap
        load(8'h02, 8'h10, 8'h04, 8'h30, 8'h06, 8'h23, 8'h59, 8'h59); idle(24); // R2 30-day month
        load(8'h06, 8'd5, 8'd1, 8'd31, 8'd2, 8'd23, 8'd59, 8'd58); idle(40);     // R5 binary
        load(8'h00, 8'h05, 8'h06, 8'h10, 8'h01, 8'h11, 8'h59, 8'h59); idle(24); // R7 11AM->12PM
        load(8'h00, 8'h05, 8'h06, 8'h10, 8'h01, 8'h92, 8'h59, 8'h59); idle(24); // R7 12PM->1PM
        load(8'h00, 8'h05, 8'h06, 8'h10, 8'h01, 8'h91, 8'h59, 8'h59); idle(24); // R7 11PM->12AM
        load(8'h04, 8'd5, 8'd6, 8'd10, 8'd1, 8'h8B, 8'd59, 8'd59); idle(24);     // R7 R5 binary 12h
        wr(4'd11, 8'h82); idle(50);                                        // R6 frozen
        wr(4'd10, 8'hFF); wr(4'd12, 8'hFF); wr(4'd13, 8'h00);              // R8 ignored
        wr(4'd1, 8'h55); wr(4'd3, 8'h55); wr(4'd5, 8'h55); idle(30);
        wr(4'd11, 8'hFF); idle(20);                                        // R8 mode bits only
        wr(4'd11, 8'h02); idle(20);
        repeat (60) begin                                                  // R3 ticks, not cycles
            @(posedge clk); #2; tick = ~tick;
        end
        tick = 1'b1; idle(20);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule